// File: doc/BRIEF.md
# Counter-Ticket Hardware Semaphore

This block lets several hosts or agents share one configuration gateway without an atomic test-and-set. It sits behind a plain 32-bit register port and exposes two words. One is a ticket counter that hands out a fresh nonzero number on every read. The other is a lock word that holds the ticket of the current owner, or zero while nobody holds it.

To acquire the lock, an agent reads a ticket and writes that value into the lock word. It then reads the lock word back. The agent owns the gateway only if the readback equals its own ticket. A losing agent sees the winner's ticket instead and must retry later. The owner releases the gateway by writing zero.

Retry loops, back-off and the host-side bus decoder that produces the register strobes are outside this block.

Top module: `ticket_semaphore`

## Requirements
- R1: After a synchronous active-low reset, the lock word reads 0 (free) and the first ticket read returns 1.
- R2: The ticket counter sits at dword offset 2 (byte 0x8). Each read there returns the current ticket and advances the counter by one for the next read.
- R3: The ticket counter is TICKET_W bits wide, zero-extended on the read port. After the value 2^TICKET_W-1 the next ticket is 1, so a ticket is never 0.
- R4: The lock word sits at dword offset 3 (byte 0xC). While it is 0, a write there stores the full 32-bit write data, and later reads return that value.
- R5: While the lock word is nonzero, a nonzero write to it is ignored and the owner's value is kept.
- R6: A write of 0 to the lock word clears it, whatever it held before.
- R7: Accesses to any other offset read as 0 and leave both the lock word and the ticket counter unchanged. A lock-word read does not advance the counter.
- R8: Read data is valid combinationally in the same cycle as the read strobe and shows the value held before that cycle's clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_off | input | OFF_W | Dword offset of the access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | DATA_W | Read data |

## Verification
The ticket counter is tested with a run of consecutive reads longer than one full wrap. This separates correct increments from a missed wrap or from a wrap that lands on 0. Lock acquisition is tested with two competing agents, which tells a correct owner hold (R5) apart from last-writer-wins. The second agent also releases the lock, which shows that zero always frees it. A sweep over every other offset, with all-ones writes and reads, shows that foreign accesses disturb neither register. Reads of the counter between these steps expose any stray advance.

// File: rtl/ticket_sem_pkg.sv
// Package: shared constants for the counter-ticket semaphore.
// Assumes dword-addressed register port; byte offsets divided by four.
package ticket_sem_pkg;
    localparam int unsigned TICKET_BYTE_OFF = 8;
    localparam int unsigned LOCK_BYTE_OFF   = 12;
    localparam int unsigned TICKET_DW_OFF   = TICKET_BYTE_OFF / 4;
    localparam int unsigned LOCK_DW_OFF     = LOCK_BYTE_OFF / 4;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_TICKET = 2'd1,
        SEL_LOCK   = 2'd2
    } reg_sel_e;
endpackage

// File: rtl/sem_reg_decode.sv
// Module: decodes the dword offset into a register select.
// Assumes only two offsets belong to this block; the rest map to SEL_NONE.
module sem_reg_decode
    import ticket_sem_pkg::*;
#(
    parameter int unsigned OFF_W = 4
) (
    input  logic [OFF_W-1:0] off,
    output reg_sel_e         sel
);
    // Purpose: map the offset to one of the block's registers.
    always_comb begin
        if (off == OFF_W'(TICKET_DW_OFF))
            sel = SEL_TICKET;
        else if (off == OFF_W'(LOCK_DW_OFF))
            sel = SEL_LOCK;
        else
            sel = SEL_NONE;
    end
endmodule

// File: rtl/ticket_counter.sv
// Module: ticket source that skips zero on wrap.
// Assumes `advance` is asserted for one cycle per consumed ticket.
module ticket_counter #(
    parameter int unsigned TICKET_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                advance,
    output logic [TICKET_W-1:0] ticket
);
    localparam logic [TICKET_W-1:0] T_ONE = TICKET_W'(1);
    localparam logic [TICKET_W-1:0] T_MAX = {TICKET_W{1'b1}};

    // Purpose: hold the next ticket; reset to 1, wrap from max to 1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ticket <= T_ONE;
        else if (advance)
            ticket <= (ticket == T_MAX) ? T_ONE : ticket + T_ONE;
    end
endmodule

// File: rtl/lock_word_reg.sv
// Module: owner word; a nonzero value sticks until zero is written.
// Assumes `wr_en` is a decoded write strobe for the lock offset.
module lock_word_reg #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] word
);
    logic is_free;
    logic is_release;

    // Purpose: classify the current state and the incoming write.
    always_comb begin
        is_free    = (word == '0);
        is_release = (wdata == '0);
    end

    // Purpose: release on zero, take only while free, else keep the owner.
    always_ff @(posedge clk) begin
        if (!rst_n)
            word <= '0;
        else if (wr_en && (is_release || is_free))
            word <= wdata;
    end
endmodule

// File: rtl/ticket_semaphore.sv
// Module: counter-ticket semaphore behind a 32-bit register port.
// Assumes single-cycle strobes; read data is combinational from state.
module ticket_semaphore
    import ticket_sem_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned TICKET_W = 8,
    parameter int unsigned OFF_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFF_W-1:0]  reg_off,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_rd,
    output logic [DATA_W-1:0] reg_rdata
);
    reg_sel_e            sel;
    logic [TICKET_W-1:0] ticket_q;
    logic [DATA_W-1:0]   lock_q;
    logic [DATA_W-1:0]   ticket_ext;
    logic                take_ticket;
    logic                lock_wr;

    sem_reg_decode #(.OFF_W(OFF_W)) u_dec (
        .off (reg_off),
        .sel (sel)
    );

    // Purpose: qualify strobes with the decoded register.
    always_comb begin
        take_ticket = reg_rd && (sel == SEL_TICKET);
        lock_wr     = reg_wr && (sel == SEL_LOCK);
    end

    ticket_counter #(.TICKET_W(TICKET_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (take_ticket),
        .ticket  (ticket_q)
    );

    lock_word_reg #(.DATA_W(DATA_W)) u_lock (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (lock_wr),
        .wdata (reg_wdata),
        .word  (lock_q)
    );

    // Zero-extend the ticket when it is narrower than the data port.
    generate
        if (TICKET_W < DATA_W) begin : g_pad
            assign ticket_ext = {{(DATA_W-TICKET_W){1'b0}}, ticket_q};
        end else begin : g_full
            assign ticket_ext = ticket_q[DATA_W-1:0];
        end
    endgenerate

    // Purpose: read multiplexer; unknown offsets return zero.
    always_comb begin
        unique case (sel)
            SEL_TICKET: reg_rdata = ticket_ext;
            SEL_LOCK:   reg_rdata = lock_q;
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ticket_semaphore_chk.sv
// Checker: temporal properties of the semaphore, bound to the top module.
module ticket_semaphore_chk
    import ticket_sem_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned TICKET_W = 8,
    parameter int unsigned OFF_W    = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [OFF_W-1:0]    reg_off,
    input logic                reg_wr,
    input logic [DATA_W-1:0]   reg_wdata,
    input logic                reg_rd,
    input logic [TICKET_W-1:0] ticket,
    input logic [DATA_W-1:0]   lock_word
);
    logic hit_t, hit_l;
    assign hit_t = (reg_off == OFF_W'(TICKET_DW_OFF));
    assign hit_l = (reg_off == OFF_W'(LOCK_DW_OFF));

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (lock_word == '0 && ticket == TICKET_W'(1)));

    p_ticket_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && hit_t) |=> ticket != $past(ticket));

    p_ticket_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ticket != '0);

    p_take_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && hit_l && lock_word == '0) |=> lock_word == $past(reg_wdata));

    p_owner_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_word != '0 && !(reg_wr && hit_l && reg_wdata == '0)) |=> $stable(lock_word));

    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && hit_l && reg_wdata == '0) |=> lock_word == '0);

    p_ticket_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && hit_t) |=> $stable(ticket));

    p_lock_foreign_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && hit_l) |=> $stable(lock_word));
endmodule

bind ticket_semaphore ticket_semaphore_chk #(
    .DATA_W(DATA_W), .TICKET_W(TICKET_W), .OFF_W(OFF_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_off   (reg_off),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rd    (reg_rd),
    .ticket    (ticket_q),
    .lock_word (lock_q)
);

// File: tb/test_ticket_semaphore.sv
module test_ticket_semaphore;
    localparam int CLK_PERIOD = 10;
    localparam int TMAX = 255;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [3:0]  reg_off = '0;
    logic        reg_wr = 0;
    logic [31:0] reg_wdata = '0;
    logic        reg_rd = 0;
    logic [31:0] reg_rdata;

    int n_chk = 0;
    int n_fail = 0;
    int exp_t = 1;
    bit done = 0;

    ticket_semaphore i_ticket_semaphore (
        .clk(clk), .rst_n(rst_n), .reg_off(reg_off), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] off, output logic [31:0] d);
        @(negedge clk);
        reg_off = off; reg_rd = 1;
        #1 d = reg_rdata;
        @(posedge clk); #1 reg_rd = 0;
    endtask

    task automatic wr(input logic [3:0] off, input logic [31:0] d);
        @(negedge clk);
        reg_off = off; reg_wr = 1; reg_wdata = d;
        @(posedge clk); #1 reg_wr = 0;
    endtask

    // Reads a ticket and checks it against the arithmetic model.
    task automatic take_ticket(input string req, output logic [31:0] t);
        rd(4'd2, t);
        check(req, t, 32'(exp_t));
        exp_t = (exp_t == TMAX) ? 1 : exp_t + 1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] d, ta, tb;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R1: reset state
        rd(4'd3, d); check("R1 lock after reset", d, 32'h0);
        take_ticket("R1 first ticket", d);

        // R2/R3/R8: sweep past one full wrap
        for (int i = 0; i < 300; i++) take_ticket("R2 R3 R8 ticket sequence", d);

        // R4/R5: two agents compete
        take_ticket("R2 agent A ticket", ta);
        take_ticket("R2 agent B ticket", tb);
        wr(4'd3, ta);
        rd(4'd3, d); check("R4 A owns", d, ta);
        wr(4'd3, tb);
        rd(4'd3, d); check("R5 B ignored", d, ta);
        wr(4'd3, 32'hFFFF_FFFF);
        rd(4'd3, d); check("R5 all-ones ignored", d, ta);
        // R7: lock reads do not advance the counter
        take_ticket("R7 counter after lock reads", d);

        // R6: release by the other agent, and zero while free
        wr(4'd3, 32'h0);
        rd(4'd3, d); check("R6 released", d, 32'h0);
        wr(4'd3, 32'h0);
        rd(4'd3, d); check("R6 zero while free", d, 32'h0);

        // R4: full 32-bit value stored while free
        wr(4'd3, 32'h8000_0001);
        rd(4'd3, d); check("R4 full width", d, 32'h8000_0001);

        // R7: sweep foreign offsets
        for (int o = 0; o < 16; o++) begin
            if (o != 2 && o != 3) begin
                wr(4'(o), 32'hFFFF_FFFF);
                wr(4'(o), 32'h0);
                rd(4'(o), d); check("R7 foreign read zero", d, 32'h0);
            end
        end
        rd(4'd3, d); check("R7 lock untouched", d, 32'h8000_0001);
        take_ticket("R7 counter untouched", d);

        // Writes to the counter offset do not alter it (R7)
        wr(4'd2, 32'h0000_0000);
        take_ticket("R7 counter write ignored", d);

        wr(4'd3, 32'h0);
        take_ticket("R2 after release", ta);
        wr(4'd3, ta);
        rd(4'd3, d); check("R4 reacquire", d, ta);

        finish_run();
    end
endmodule